// File: doc/BRIEF.md
# Block-Erase Flash Array Emulator

This block is a synthesizable on-chip stand-in for a NOR-style flash array. It keeps the write rules of real flash. A word can be read at any time the block is idle. Programming can only pull bits from one to zero, because the stored result is the bitwise AND of the old word and the new data. The only way back to ones is to erase a whole block. Program and erase each run for a fixed number of cycles, and the busy output stays high for that time.

The array is divided into equal erase blocks. Block 0 holds boot code and is guarded: a program or erase aimed at it is refused unless the unlock input is high in the cycle the command is issued. A refused command, or any command that arrives while an operation is running, is dropped and sets a sticky error flag. Only reset clears that flag. After reset every word reads as all ones.

Top module: `flash_emu`

## Requirements
- R1: After reset, busy_o and err_o are 0 and every word reads as all ones.
- R2: A read command (cmd_i = 1) accepted while idle raises rd_valid_o for exactly the next cycle, with the addressed word on rd_data_o. busy_o stays 0.
- R3: A program command (cmd_i = 2) stores the bitwise AND of the current word and wdata_i, so no bit ever changes from 0 to 1.
- R4: An accepted program holds busy_o high for exactly PROG_CYC cycles (default 4). The new value can be read once busy_o falls.
- R5: An erase command (cmd_i = 3) sets every word of the block selected by addr_i[9:7] to all ones and leaves every other block unchanged.
- R6: An accepted erase holds busy_o high for exactly ERASE_CYC cycles (default 32).
- R7: A command other than NOP (cmd_i = 0) that arrives while busy_o is high is ignored, produces no rd_valid_o, and sets err_o.
- R8: A program or erase aimed at block 0 while unlock_i is low is refused: busy_o stays 0, err_o is set, and the contents do not change.
- R9: With unlock_i high, program and erase of block 0 proceed like those of any other block, and err_o is not set.
- R10: err_o stays high from the moment it is set until the next reset, and successful operations that follow do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command code: 0 NOP, 1 read, 2 program, 3 erase block |
| addr_i | input | 10 | Word address. Bits 9:7 select the erase block |
| wdata_i | input | 16 | Program data |
| unlock_i | input | 1 | Allows program and erase of block 0 |
| rd_data_o | output | 16 | Read result, valid while rd_valid_o is high |
| rd_valid_o | output | 1 | One-cycle strobe after an accepted read |
| busy_o | output | 1 | High while a program or erase is in progress |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions check the control rules on every cycle: the zero-wait read strobe, the exact length of each busy window, the error raised by a command during busy or by a guarded command, the refusal of guarded commands without busy, the stickiness of the error flag, and the clearing of liveness for an erased block. Only the bench scenarios can show the data itself. These cover AND accumulation over repeated programs, block-wide erase leaving the neighbouring blocks intact, and refused operations leaving block 0 unchanged. They also cover the unlocked path, which changes block 0.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_PROG  = 2'd2,
    CMD_ERASE = 2'd3
  } flash_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } flash_state_e;
endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/flash_erase_map.sv
module flash_erase_map #(
  parameter int DEPTH     = 1024,
  parameter int BLK_WORDS = 128,
  localparam int NUM_BLKS = DEPTH / BLK_WORDS,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int BLK_W    = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_en_i,
  input  logic [BLK_W-1:0]  clr_blk_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              live_o
);
  logic [DEPTH-1:0] live_q;
  logic [DEPTH-1:0] blk_mask;
  logic             live_rd_q;

  for (genvar g = 0; g < NUM_BLKS; g++) begin : g_mask
    assign blk_mask[g*BLK_WORDS +: BLK_WORDS] =
      {BLK_WORDS{clr_en_i && (clr_blk_i == BLK_W'(g))}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= '0;
      live_rd_q <= 1'b0;
    end else begin
      if (set_en_i) live_q[set_addr_i] <= 1'b1;
      if (clr_en_i) live_q <= live_q & ~blk_mask;
      if (re_i) live_rd_q <= live_q[raddr_i];
    end
  end

  assign live_o = live_rd_q;

  p_erase_clears_r5: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> ((live_q & $past(blk_mask)) == '0));
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int DEPTH     = 1024,
  parameter int BLK_WORDS = 128,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 32,
  localparam int NUM_BLKS = DEPTH / BLK_WORDS,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int BLK_W    = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int MAX_CYC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              unlock_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              erase_en_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [BLK_W-1:0]  op_blk_o,
  output logic [WORD_W-1:0] op_data_o
);
  flash_state_e      state_q;
  flash_cmd_e        cmd;
  logic [CNT_W-1:0]  timer_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              err_q, rd_valid_q;
  logic              idle, is_mod, guarded, accept_rd, start, refuse, done;

  assign cmd       = flash_cmd_e'(cmd_i);
  assign idle      = (state_q == ST_IDLE);
  assign is_mod    = (cmd == CMD_PROG) || (cmd == CMD_ERASE);
  assign guarded   = (addr_i[ADDR_W-1 -: BLK_W] == '0) && !unlock_i;
  assign accept_rd = idle && (cmd == CMD_READ);
  assign start     = idle && is_mod && !guarded;
  assign refuse    = (!idle && cmd != CMD_NOP) || (idle && is_mod && guarded);
  assign done      = !idle && (timer_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      timer_q    <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= accept_rd;
      if (refuse) err_q <= 1'b1;
      if (idle) begin
        if (start) begin
          addr_q <= addr_i;
          data_q <= data_i;
          if (cmd == CMD_PROG) begin
            state_q <= ST_PROG;
            timer_q <= CNT_W'(PROG_CYC - 1);
          end else begin
            state_q <= ST_ERASE;
            timer_q <= CNT_W'(ERASE_CYC - 1);
          end
        end
      end else if (done) begin
        state_q <= ST_IDLE;
      end else begin
        timer_q <= timer_q - 1'b1;
      end
    end
  end

  assign busy_o     = !idle;
  assign err_o      = err_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_en_o    = accept_rd || (start && cmd == CMD_PROG);
  assign wr_en_o    = done && (state_q == ST_PROG);
  assign erase_en_o = done && (state_q == ST_ERASE);
  assign op_addr_o  = addr_q;
  assign op_blk_o   = addr_q[ADDR_W-1 -: BLK_W];
  assign op_data_o  = data_q;

  // Busy-window checker: counts busy cycles, compares on the falling edge.
  logic [CNT_W:0] chk_cnt;
  logic           chk_prog;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_cnt  <= '0;
      chk_prog <= 1'b0;
    end else begin
      chk_cnt <= busy_o ? chk_cnt + 1'b1 : '0;
      if (start) chk_prog <= (cmd == CMD_PROG);
    end
  end

  p_busy_len_r4_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (chk_cnt == (chk_prog ? (CNT_W+1)'(PROG_CYC) : (CNT_W+1)'(ERASE_CYC))));
  p_read_nowait_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_READ && !busy_o) |=> (rd_valid_o && !busy_o));
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cmd != CMD_NOP) |=> (err_o && !rd_valid_o));
  p_protect_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && is_mod && addr_i[ADDR_W-1 -: BLK_W] == '0 && !unlock_i) |=> (!busy_o && err_o));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: rtl/flash_emu.sv
module flash_emu #(
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 128,
  parameter int NUM_BLKS  = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 32,
  localparam int DEPTH    = BLK_WORDS * NUM_BLKS,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int BLK_W    = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              unlock_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              err_o
);
  logic              rd_en, wr_en, erase_en, live;
  logic [ADDR_W-1:0] op_addr;
  logic [BLK_W-1:0]  op_blk;
  logic [WORD_W-1:0] op_data, arr_word, cur_word;

  flash_ctrl #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .BLK_WORDS(BLK_WORDS),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .addr_i(addr_i), .data_i(wdata_i),
    .unlock_i(unlock_i), .busy_o(busy_o), .err_o(err_o), .rd_valid_o(rd_valid_o),
    .rd_en_o(rd_en), .wr_en_o(wr_en), .erase_en_o(erase_en),
    .op_addr_o(op_addr), .op_blk_o(op_blk), .op_data_o(op_data)
  );

  flash_cell_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) array_i (
    .clk(clk), .re_i(rd_en), .raddr_i(addr_i), .rdata_o(arr_word),
    .we_i(wr_en), .waddr_i(op_addr), .wdata_i(op_data & cur_word)
  );

  flash_erase_map #(.DEPTH(DEPTH), .BLK_WORDS(BLK_WORDS)) emap_i (
    .clk(clk), .rst(rst), .set_en_i(wr_en), .set_addr_i(op_addr),
    .clr_en_i(erase_en), .clr_blk_i(op_blk), .re_i(rd_en), .raddr_i(addr_i),
    .live_o(live)
  );

  // A word never programmed since reset or its last erase reads as all ones.
  assign cur_word  = live ? arr_word : '1;
  assign rd_data_o = cur_word;
endmodule

// File: tb/flash_emu_tb.sv
module flash_emu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_N  = 4;
  localparam int ERASE_N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cmd = 2'd0;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        unlock = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid, busy, err;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] model [1024];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_emu dut_i (
    .clk(clk), .rst(rst), .cmd_i(cmd), .addr_i(addr), .wdata_i(wdata),
    .unlock_i(unlock), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .busy_o(busy), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a read result appears.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected read strobe", int'(rd_data), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, int'(rd_data), int'(e));
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 1024; i++) model[i] = 16'hFFFF;
  endtask

  task automatic send(input logic [1:0] c, input int a, input logic [15:0] d, input logic u);
    @(posedge clk);
    #1 cmd = c; addr = 10'(a); wdata = d; unlock = u;
    @(posedge clk);
    #1 cmd = 2'd0; unlock = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_read(input int a, input string t);
    exp_q.push_back(model[a]);
    tag_q.push_back(t);
    send(2'd1, a, 16'h0, 1'b0);
    check(!busy, "R2 busy during read", int'(busy), 0);
  endtask

  task automatic do_prog(input int a, input logic [15:0] d, input logic u);
    int n;
    send(2'd2, a, d, u);
    wait_idle(n);
    check(n == PROG_N, "R4 program busy length", n, PROG_N);
    model[a] = model[a] & d;
  endtask

  task automatic do_erase(input int a, input logic u);
    int n;
    int b;
    send(2'd3, a, 16'h0, u);
    wait_idle(n);
    check(n == ERASE_N, "R6 erase busy length", n, ERASE_N);
    b = a / 128;
    for (int i = b * 128; i < b * 128 + 128; i++) model[i] = 16'hFFFF;
  endtask

  initial begin
    int n;
    do_reset();
    // R1: reset state
    check(!busy && !err, "R1 busy/err after reset", {busy, err}, 0);
    do_read(0, "R1 erased word 0");
    do_read(1023, "R1 erased word 1023");
    do_read(517, "R1 erased word 517");

    // R3/R4: program accumulates as AND
    do_prog(200, 16'hA5F0, 1'b0);
    do_read(200, "R4 programmed value");
    do_prog(200, 16'h0FFF, 1'b0);
    do_read(200, "R3 AND of two programs");
    do_prog(200, 16'hFFFF, 1'b0);
    do_read(200, "R3 ones cannot be restored");
    do_read(201, "R3 neighbour untouched");

    // R5/R6: block erase
    do_prog(256, 16'h1234, 1'b0);
    do_prog(383, 16'h00FF, 1'b0);
    do_prog(384, 16'hBEEF, 1'b0);
    do_erase(300, 1'b0);
    do_read(256, "R5 block 2 first word erased");
    do_read(383, "R5 block 2 last word erased");
    do_read(384, "R5 block 3 kept");
    do_read(200, "R5 block 1 kept");
    check(!err, "R10 no error yet", int'(err), 0);

    // R7: command while busy is ignored
    send(2'd2, 700, 16'h3C3C, 1'b0);
    #0 cmd = 2'd1; addr = 10'd384;
    @(posedge clk);
    #1 cmd = 2'd0;
    check(err, "R7 error after command during busy", int'(err), 1);
    #0 cmd = 2'd3; addr = 10'd700;
    @(posedge clk);
    #1 cmd = 2'd0;
    wait_idle(n);
    model[700] = 16'h3C3C;
    do_read(700, "R7 erase during busy ignored");
    // R10: still set after successful operations
    do_prog(701, 16'h0001, 1'b0);
    check(err, "R10 error sticky", int'(err), 1);

    // R1: reset clears error and contents
    do_reset();
    check(!err, "R1 error cleared by reset", int'(err), 0);
    do_read(700, "R1 contents erased by reset");

    // R8: guarded block
    send(2'd2, 5, 16'h0000, 1'b0);
    check(!busy, "R8 refused program not busy", int'(busy), 0);
    check(err, "R8 refused program error", int'(err), 1);
    do_read(5, "R8 block 0 unchanged");
    send(2'd3, 10, 16'h0000, 1'b0);
    check(!busy, "R8 refused erase not busy", int'(busy), 0);

    // R9: unlocked access to block 0
    do_reset();
    do_prog(5, 16'h5A5A, 1'b1);
    do_read(5, "R9 unlocked program");
    do_prog(127, 16'h0F0F, 1'b1);
    check(!err, "R9 no error with unlock", int'(err), 0);
    send(2'd3, 3, 16'h0, 1'b0);
    do_read(5, "R8 locked erase refused");
    do_erase(3, 1'b1);
    do_read(5, "R9 unlocked erase");
    do_read(127, "R9 unlocked erase last word");

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
    end
    $finish;
  end
endmodule